// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies a run of equally sized data items from a source region to a destination region through a single synchronous memory master port. Software describes a job with four 32-bit words: a configuration word, the address of the last source item, the address of the last destination item and a link to a further job held in memory. The channel works out each item's address backwards from the stored last address. The stride is the item width times an increment factor, and the remaining-item count sets how far back to go. Only the last addresses are stored, so no start address has to be kept.

A job is loaded through the register inputs and starts once the channel is enabled, the job is marked valid and a trigger is pending. When the item count runs out, the channel can raise either or both of two completion flags. If the job asks for it, the channel also fetches the next four-word job from the link address into its working registers and carries on. An item width that cannot be decoded, or a last address not aligned to the item width, sets an error flag and stops the channel. Dropping the enable stops a running job at a beat boundary.

Top module: `dma_chain_engine`

## Requirements
- R1: Configuration word layout: bit 0 valid, bit 1 reload, bit 2 software trigger, bit 3 clear-trigger, bit 4 completion flag A select, bit 5 completion flag B select, bits 9:8 width code, bits 13:12 source increment code, bits 15:14 destination increment code, bits 25:16 item count minus one. A job is loaded with cfg_wr_i only while busy_o is low.
- R2: Width code 0, 1 and 2 select 1, 2 and 4 byte items. mem_size_o carries the width code for data beats and 2 for job fetches. Data is right-justified on mem_rdata_i and mem_wdata_i.
- R3: Increment codes 0, 1, 2 and 3 give a stride of 0, 1, 2 and 4 item widths. Item k of n (counting from 0) uses address last − stride × (n − 1 − k), so the final item uses the stored last address.
- R4: remaining_o holds the number of items not yet written: count field + 1 after a load or fetch, minus one for each write beat.
- R5: Each item takes a read request at its source address, then a write request at its destination address in the next cycle. The write carries the data that the memory returns for the read.
- R6: When a job's last item is written, flag A sets if bit 4 is set and flag B sets if bit 5 is set. Flags stay set until flag_clr_i bit 0 (A), bit 1 (B) or bit 2 (error) is pulsed.
- R7: With reload set, a finished job is followed by reads of four words at the link address with its low four bits forced to zero. The words are taken as configuration, last source, last destination and link, and the new job runs under the usual start rule.
- R8: Width code 3, or a last source or destination address not aligned to the item width, sets the error flag. The channel then makes no memory access for that job, drops the job and the trigger, and goes idle.
- R9: busy_o is high whenever the channel is sequencing (checking, moving data or fetching). active_o is high while the channel is enabled and holds a valid job. No memory request is made while busy_o is low.
- R10: A job with clear-trigger set drops the pending trigger when it finishes. A linked job fetched after it then waits, with active_o high and busy_o low, until a new trigger arrives.
- R11: A fetched configuration word with bit 0 clear leaves the channel idle, with no data movement, no error and active_o low.
- R12: Clearing enable_i during a job stops it after the beat in progress, drops the job and the trigger, leaves remaining_o at the number of unwritten items, and sets no completion flag.
- R13: A job starts only when the enable, the valid bit and a pending trigger are all present. The trigger is set by a pulse on sw_trig_i or by bit 2 of a loaded or fetched configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Channel enable |
| cfg_wr_i | input | 1 | Load the four job words below |
| cfg_word_i | input | 32 | Configuration word |
| src_end_i | input | 32 | Last source address |
| dst_end_i | input | 32 | Last destination address |
| link_i | input | 32 | Next job address |
| sw_trig_i | input | 1 | Trigger pulse |
| flag_clr_i | input | 3 | Clear flag A, B, error |
| busy_o | output | 1 | Channel sequencing |
| active_o | output | 1 | Enabled with a valid job |
| remaining_o | output | 11 | Items not yet written |
| irq_a_o | output | 1 | Completion flag A |
| irq_b_o | output | 1 | Completion flag B |
| err_o | output | 1 | Address or width error flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_size_o | output | 2 | Access size code |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_rdata_i | input | 32 | Read data, one cycle after the read |

## Verification
The hardest state to reach is a linked job that has been fetched but held back because the previous job dropped the trigger. From the ports this looks like an idle channel, and only active_o and remaining_o show what it holds. The bench builds that state by storing a second job in the memory model, starting a first job with reload and clear-trigger set, and waiting until the channel stays quiet. It then checks that the second destination region is untouched before it pulses the trigger and compares the final memory. A sweep over every width and increment pairing, with item counts from one to five, checks the backward address arithmetic against byte images that the bench computes.

// File: rtl/dma_chain_pkg.sv
// Shared field positions, state type and decode helpers for the linked
// descriptor DMA channel. Assumes a 32-bit configuration word.
package dma_chain_pkg;
    localparam int WORD_W     = 32;
    localparam int B_VALID    = 0;
    localparam int B_RELOAD   = 1;
    localparam int B_SWTRIG   = 2;
    localparam int B_CLRTRIG  = 3;
    localparam int B_SEL_A    = 4;
    localparam int B_SEL_B    = 5;
    localparam int F_WIDTH    = 8;
    localparam int F_SRC_INC  = 12;
    localparam int F_DST_INC  = 14;
    localparam int F_COUNT    = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_DONE, ST_FETCH, ST_FLAST
    } chan_state_e;

    // Increment code to a power-of-two multiplier of the width (code 0 unused).
    function automatic logic [1:0] inc_shift(input logic [1:0] code);
        case (code)
            2'd2:    inc_shift = 2'd1;
            2'd3:    inc_shift = 2'd2;
            default: inc_shift = 2'd0;
        endcase
    endfunction

    // True when an address is illegal for the given width code.
    function automatic logic addr_bad(input logic [1:0] wcode, input logic [1:0] low);
        case (wcode)
            2'd0:    addr_bad = 1'b0;
            2'd1:    addr_bad = low[0];
            2'd2:    addr_bad = |low;
            default: addr_bad = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/dma_addr_gen.sv
// Computes the current item address backwards from a last address:
// last - (left-1) * (width << incshift). Assumes left >= 1 whenever the
// result is used and a width code of 0..2.
module dma_addr_gen
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic [1:0]        width_i,
    input  logic [1:0]        inc_i,
    input  logic [CNT_W:0]    left_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [2:0]        shift;
    logic [ADDR_W-1:0] steps;

    // Backward offset from the last address; zero stride keeps it fixed.
    always_comb begin
        shift = {1'b0, width_i} + {1'b0, inc_shift(inc_i)};
        steps = ADDR_W'(left_i) - ADDR_W'(1);
        if (inc_i == 2'd0) addr_o = end_addr_i;
        else               addr_o = end_addr_i - (steps << shift);
    end
endmodule

// File: rtl/dma_status_flags.sv
// Sticky completion and error flags. A set and a clear in the same
// cycle leave the flag set.
module dma_status_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_a_i,
    input  logic       set_b_i,
    input  logic       set_err_i,
    input  logic [2:0] clr_i,
    output logic       irq_a_o,
    output logic       irq_b_o,
    output logic       err_o
);
    // Hold each flag until its clear bit is pulsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_a_o <= 1'b0;
            irq_b_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            irq_a_o <= set_a_i   | (irq_a_o & ~clr_i[0]);
            irq_b_o <= set_b_i   | (irq_b_o & ~clr_i[1]);
            err_o   <= set_err_i | (err_o   & ~clr_i[2]);
        end
    end

    assert_flag_a_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a_o) |-> $past(set_a_i));
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(set_err_i));
endmodule

// File: rtl/dma_sequencer.sv
// Channel state machine: holds the working job registers, runs the
// check / read / write / complete / fetch sequence and drives the memory
// port. Assumes a memory that accepts a request every cycle and returns
// read data in the following cycle.
module dma_sequencer
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              sw_trig_i,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic [ADDR_W-1:0] src_end_i,
    input  logic [ADDR_W-1:0] dst_end_i,
    input  logic [ADDR_W-1:0] link_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    output logic [WORD_W-1:0] cfg_o,
    output logic [ADDR_W-1:0] src_end_o,
    output logic [ADDR_W-1:0] dst_end_o,
    output logic [CNT_W:0]    left_o,
    output logic              busy_o,
    output logic              active_o,
    output logic              set_a_o,
    output logic              set_b_o,
    output logic              set_err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);
    chan_state_e       st_q;
    logic [WORD_W-1:0] cfg_q;
    logic [ADDR_W-1:0] src_end_q, dst_end_q, link_q;
    logic [CNT_W:0]    left_q;
    logic              trig_q;
    logic [1:0]        fidx_q;
    logic [1:0]        wcode;
    logic              job_bad;
    logic [ADDR_W-1:0] link_base;

    // Decode the working configuration and the alignment check.
    always_comb begin
        wcode     = cfg_q[F_WIDTH +: 2];
        job_bad   = addr_bad(wcode, src_end_q[1:0]) | addr_bad(wcode, dst_end_q[1:0]);
        link_base = link_q & ~ADDR_W'(15);
    end

    // Job sequencing and working register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cfg_q     <= '0;
            src_end_q <= '0;
            dst_end_q <= '0;
            link_q    <= '0;
            left_q    <= '0;
            trig_q    <= 1'b0;
            fidx_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cfg_wr_i) begin
                        cfg_q     <= cfg_word_i;
                        src_end_q <= src_end_i;
                        dst_end_q <= dst_end_i;
                        link_q    <= link_i;
                        left_q    <= {1'b0, cfg_word_i[F_COUNT +: CNT_W]} + 1'b1;
                        if (cfg_word_i[B_SWTRIG]) trig_q <= 1'b1;
                    end else if (enable_i && cfg_q[B_VALID] && trig_q) begin
                        st_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (job_bad) begin
                        cfg_q[B_VALID] <= 1'b0;
                        trig_q         <= 1'b0;
                        st_q           <= ST_IDLE;
                    end else begin
                        st_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (!enable_i) begin
                        cfg_q[B_VALID] <= 1'b0;
                        trig_q         <= 1'b0;
                        st_q           <= ST_IDLE;
                    end else begin
                        st_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    left_q <= left_q - 1'b1;
                    if (left_q == {{CNT_W{1'b0}}, 1'b1}) begin
                        st_q <= ST_DONE;
                    end else if (!enable_i) begin
                        cfg_q[B_VALID] <= 1'b0;
                        trig_q         <= 1'b0;
                        st_q           <= ST_IDLE;
                    end else begin
                        st_q <= ST_READ;
                    end
                end
                ST_DONE: begin
                    if (cfg_q[B_CLRTRIG]) trig_q <= 1'b0;
                    if (cfg_q[B_RELOAD]) begin
                        fidx_q <= '0;
                        st_q   <= ST_FETCH;
                    end else begin
                        cfg_q[B_VALID] <= 1'b0;
                        st_q           <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    case (fidx_q)
                        2'd1:    cfg_q     <= mem_rdata_i;
                        2'd2:    src_end_q <= mem_rdata_i;
                        2'd3:    dst_end_q <= mem_rdata_i;
                        default: ;
                    endcase
                    fidx_q <= fidx_q + 1'b1;
                    if (fidx_q == 2'd3) st_q <= ST_FLAST;
                end
                ST_FLAST: begin
                    link_q <= mem_rdata_i;
                    left_q <= {1'b0, cfg_q[F_COUNT +: CNT_W]} + 1'b1;
                    if (cfg_q[B_SWTRIG]) trig_q <= 1'b1;
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (sw_trig_i) trig_q <= 1'b1;
        end
    end

    // Memory port and status outputs.
    always_comb begin
        mem_req_o   = ((st_q == ST_READ) && enable_i) || (st_q == ST_WRITE) || (st_q == ST_FETCH);
        mem_we_o    = (st_q == ST_WRITE);
        mem_size_o  = (st_q == ST_FETCH) ? 2'd2 : wcode;
        mem_wdata_o = mem_rdata_i;
        case (st_q)
            ST_READ:  mem_addr_o = src_addr_i;
            ST_WRITE: mem_addr_o = dst_addr_i;
            default:  mem_addr_o = link_base + ADDR_W'({fidx_q, 2'b00});
        endcase
        busy_o    = (st_q != ST_IDLE);
        active_o  = enable_i && cfg_q[B_VALID];
        set_a_o   = (st_q == ST_DONE) && cfg_q[B_SEL_A];
        set_b_o   = (st_q == ST_DONE) && cfg_q[B_SEL_B];
        set_err_o = (st_q == ST_CHECK) && job_bad;
        cfg_o     = cfg_q;
        src_end_o = src_end_q;
        dst_end_o = dst_end_q;
        left_o    = left_q;
    end

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |=> (left_o == $past(left_o) - 1'b1));
    assert_access_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !addr_bad(mem_size_o, mem_addr_o[1:0]));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);
endmodule

// File: rtl/dma_chain_engine.sv
// Top of the linked-descriptor DMA channel: the sequencer, two backward
// address generators (source, destination) and the status flags.
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              cfg_wr_i,
    input  logic [31:0]       cfg_word_i,
    input  logic [ADDR_W-1:0] src_end_i,
    input  logic [ADDR_W-1:0] dst_end_i,
    input  logic [ADDR_W-1:0] link_i,
    input  logic              sw_trig_i,
    input  logic [2:0]        flag_clr_i,
    output logic              busy_o,
    output logic              active_o,
    output logic [CNT_W:0]    remaining_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic              err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i
);
    logic [WORD_W-1:0] cfg;
    logic [ADDR_W-1:0] src_end, dst_end, src_addr, dst_addr;
    logic              set_a, set_b, set_err;

    dma_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sw_trig_i(sw_trig_i),
        .cfg_wr_i(cfg_wr_i), .cfg_word_i(cfg_word_i), .src_end_i(src_end_i),
        .dst_end_i(dst_end_i), .link_i(link_i), .src_addr_i(src_addr),
        .dst_addr_i(dst_addr), .cfg_o(cfg), .src_end_o(src_end),
        .dst_end_o(dst_end), .left_o(remaining_o), .busy_o(busy_o),
        .active_o(active_o), .set_a_o(set_a), .set_b_o(set_b),
        .set_err_o(set_err), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_src_gen (
        .end_addr_i(src_end), .width_i(cfg[F_WIDTH +: 2]),
        .inc_i(cfg[F_SRC_INC +: 2]), .left_i(remaining_o), .addr_o(src_addr)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dst_gen (
        .end_addr_i(dst_end), .width_i(cfg[F_WIDTH +: 2]),
        .inc_i(cfg[F_DST_INC +: 2]), .left_i(remaining_o), .addr_o(dst_addr)
    );

    dma_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_a_i(set_a), .set_b_i(set_b),
        .set_err_i(set_err), .clr_i(flag_clr_i), .irq_a_o(irq_a_o),
        .irq_b_o(irq_b_o), .err_o(err_o)
    );
endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, cfg_wr = 1'b0, sw_trig = 1'b0;
    logic [31:0] cfg_word = '0, src_end = '0, dst_end = '0, link = '0;
    logic [2:0]  flag_clr = '0;
    logic        busy, active, irq_a, irq_b, err, mem_req, mem_we;
    logic [10:0] remaining;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] mem [0:4095];
    logic [7:0] expm [0:4095];
    int errors = 0, checks = 0, wcnt = 0, cycles = 0;

    always #10 clk = ~clk;

    dma_chain_engine i_dma_chain_engine (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .cfg_wr_i(cfg_wr),
        .cfg_word_i(cfg_word), .src_end_i(src_end), .dst_end_i(dst_end),
        .link_i(link), .sw_trig_i(sw_trig), .flag_clr_i(flag_clr),
        .busy_o(busy), .active_o(active), .remaining_o(remaining),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .err_o(err), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // Byte memory model: one-cycle read latency, right-justified data.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[(mem_addr + b) & 32'hFFF] <= mem_wdata[8*b +: 8];
                wcnt <= wcnt + 1;
            end else begin
                logic [31:0] t;
                t = '0;
                for (int b = 0; b < (1 << mem_size); b++)
                    t[8*b +: 8] = mem[(mem_addr + b) & 32'hFFF];
                mem_rdata <= t;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit v, input bit rl, input bit sw, input bit ct,
                                       input bit ia, input bit ib, input int w, input int si,
                                       input int di, input int n);
        logic [31:0] c;
        c = '0;
        c[0] = v; c[1] = rl; c[2] = sw; c[3] = ct; c[4] = ia; c[5] = ib;
        c[9:8] = w[1:0]; c[13:12] = si[1:0]; c[15:14] = di[1:0];
        c[25:16] = 10'(n - 1);
        return c;
    endfunction

    function automatic int mult(input int code);
        return (code == 3) ? 4 : code;
    endfunction

    task automatic put32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) begin
            mem[a + b]  = v[8*b +: 8];
            expm[a + b] = v[8*b +: 8];
        end
    endtask

    task automatic init_mem(input int seed);
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = (i >= 'h100 && i < 'h300) ? 8'((i * 7 + seed) ^ (i >> 3)) : 8'hEE;
            expm[i] = mem[i];
        end
    endtask

    // Expected effect of one job given its start addresses.
    task automatic model_job(input int w, input int si, input int di, input int n,
                             input int s0, input int d0);
        int bw;
        bw = 1 << w;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < bw; b++)
                expm[d0 + k * mult(di) * bw + b] = mem[s0 + k * mult(si) * bw + b];
    endtask

    function automatic int mismatches();
        int m;
        m = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic load(input logic [31:0] c, input int se, input int de, input int lk);
        @(negedge clk);
        cfg_word = c; src_end = se; dst_end = de; link = lk; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 3'b111;
        @(negedge clk); flag_clr = 3'b000;
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        repeat (2) @(negedge clk);
        while (quiet < 3) begin
            @(negedge clk);
            if (!busy) quiet++; else quiet = 0;
        end
    endtask

    function automatic int last_addr(input int start, input int w, input int inc, input int n);
        return start + mult(inc) * (1 << w) * (n - 1);
    endfunction

    initial begin
        int w0;
        init_mem(0);
        repeat (3) @(negedge clk);
        // Reset state (R9)
        check(!busy && !active && !mem_req, "R9", "idle after reset", busy, 0);
        check(remaining == 0 && !irq_a && !irq_b && !err, "R6", "flags clear after reset", remaining, 0);
        rst_n = 1'b1;
        enable = 1'b1;

        // R13: no trigger, no start; then sw trigger runs it
        init_mem(1);
        w0 = wcnt;
        load(mk(1,0,0,1,1,0, 0,1,1, 3), 'h102, 'h802, 0);
        repeat (6) @(negedge clk);
        check(!busy && wcnt == w0 && active, "R13", "waits for trigger", wcnt - w0, 0);
        check(remaining == 3, "R4", "remaining after load", remaining, 3);
        pulse_trig();
        wait_idle();
        model_job(0, 1, 1, 3, 'h100, 'h800);
        check(mismatches() == 0, "R13", "triggered job data", mismatches(), 0);
        clear_flags();

        // Sweep widths x increments (R1 R2 R3 R5 R6 R4)
        for (int w = 0; w < 3; w++)
            for (int si = 0; si < 4; si++)
                for (int di = 0; di < 4; di++) begin
                    int n;
                    n = 1 + ((w * 16 + si * 4 + di) % 5);
                    init_mem(w * 16 + si * 4 + di);
                    load(mk(1,0,1,1,1,0, w,si,di, n), last_addr('h100, w, si, n),
                         last_addr('h800, w, di, n), 0);
                    wait_idle();
                    model_job(w, si, di, n, 'h100, 'h800);
                    check(mismatches() == 0, "R3", "backward addresses, R5 data", mismatches(), 0);
                    check(irq_a && !irq_b && !active, "R6", "flag A only on completion", irq_a, 1);
                    check(remaining == 0, "R4", "remaining at end", remaining, 0);
                    clear_flags();
                    check(!irq_a, "R6", "flag A cleared", irq_a, 0);
                end

        // R8: misaligned 16-bit source, and width code 3
        init_mem(5);
        w0 = wcnt;
        load(mk(1,0,1,1,1,0, 1,1,1, 2), 'h101, 'h802, 0);
        wait_idle();
        check(err && wcnt == w0 && !active && !irq_a, "R8", "misaligned source", wcnt - w0, 0);
        clear_flags();
        check(!err, "R6", "error flag cleared", err, 0);
        load(mk(1,0,1,1,0,0, 3,1,1, 2), 'h100, 'h800, 0);
        wait_idle();
        check(err && wcnt == w0 && mismatches() == 0, "R8", "width code 3", wcnt - w0, 0);
        clear_flags();

        // R7: chained job, link low bits ignored, trigger kept
        init_mem(9);
        put32('h400, mk(1,0,0,1,0,1, 2,1,1, 3));
        put32('h404, last_addr('h200, 2, 1, 3));
        put32('h408, last_addr('h900, 2, 1, 3));
        put32('h40C, 0);
        load(mk(1,1,1,0,1,0, 0,1,1, 4), 'h103, 'h803, 'h40C);
        wait_idle();
        model_job(0, 1, 1, 4, 'h100, 'h800);
        model_job(2, 1, 1, 3, 'h200, 'h900);
        check(mismatches() == 0, "R7", "both linked jobs", mismatches(), 0);
        check(irq_a && irq_b, "R7", "both flags after chain", {irq_a, irq_b}, 3);
        clear_flags();

        // R10: clear-trigger holds the fetched job until a new trigger
        init_mem(11);
        put32('h400, mk(1,0,0,1,0,1, 1,2,1, 2));
        put32('h404, last_addr('h200, 1, 2, 2));
        put32('h408, last_addr('h900, 1, 1, 2));
        put32('h40C, 0);
        load(mk(1,1,1,1,0,0, 0,1,1, 2), 'h101, 'h801, 'h400);
        wait_idle();
        model_job(0, 1, 1, 2, 'h100, 'h800);
        check(mismatches() == 0 && !busy, "R10", "linked job held", mismatches(), 0);
        check(active && remaining == 2, "R10", "held job loaded", remaining, 2);
        pulse_trig();
        wait_idle();
        model_job(1, 2, 1, 2, 'h200, 'h900);
        check(mismatches() == 0 && irq_b, "R10", "held job after trigger", mismatches(), 0);
        clear_flags();

        // R11: fetched word without valid bit
        init_mem(13);
        put32('h400, 32'h0000_0034);
        put32('h404, 'h100);
        put32('h408, 'h800);
        put32('h40C, 0);
        w0 = wcnt;
        load(mk(1,1,1,1,0,0, 0,1,1, 2), 'h101, 'h801, 'h400);
        wait_idle();
        model_job(0, 1, 1, 2, 'h100, 'h800);
        check(wcnt - w0 == 2 && mismatches() == 0, "R11", "no movement from invalid", wcnt - w0, 2);
        check(!active && !err && !irq_a && !irq_b, "R11", "idle with no flags", active, 0);

        // R12: abort by clearing enable
        init_mem(17);
        w0 = wcnt;
        load(mk(1,0,1,1,1,0, 0,1,1, 20), 'h113, 'h813, 0);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        wait_idle();
        check(wcnt - w0 > 0 && wcnt - w0 < 20, "R12", "stopped early", wcnt - w0, 5);
        check(remaining == 20 - (wcnt - w0), "R12", "remaining after stop", remaining, 20 - (wcnt - w0));
        check(!irq_a && !busy, "R12", "no completion flag", irq_a, 0);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(!active && !busy, "R12", "job dropped", active, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule